// File: doc/BRIEF.md
# Serial Control Port for a Broadcast Audio Decoder

This block is the two-wire serial slave that configures a multichannel broadcast audio decoder. It samples the clock and data lines with the fast system clock, removes short glitches, and detects start, stop and repeated start conditions. When the first byte after a start carries its own 7-bit address, it acknowledges. It then either takes control bytes into an 8-bit register or sends back a status byte built from the stereo and second-audio-program (SAP) detector flags.

The control register drives the decoder's mode select, forced mono, mute, level-control enable, SAP output level, input-source select and a test enable. While the test enable is set, a second byte written in the same transfer picks one of thirteen internal monitor points. A write made of a single byte returns the monitor select to normal. The data line is driven open-drain: the output enables a pull-down when it is low.

The analog detectors and the audio path are outside this block. They appear only as input flags and output control lines.

Top module: `dec_ctl_i2c`

## Requirements
- R1: After a start (data falls while clock is high), the block acknowledges the address byte 1000000 followed by R/W bit 0 (write) or 1 (read), by pulling data low while the ninth clock is high.
- R2: If the address does not match, the block gives no acknowledge, leaves data released, and ignores every byte until the next start.
- R3: Written bytes are taken most significant bit first, and each data byte of a matched write is acknowledged on its ninth clock.
- R4: A stop (data rises while clock is high) that arrives before the eighth bit of a data byte discards that byte, and every output keeps its value.
- R5: After reset the control register and the monitor select are zero and data is released.
- R6: Control byte layout: bits 1:0 give the mode (00 stereo, 01 SAP, 10 both); bit 2 is forced mono; bit 3 is mute; bit 4 is level-control enable; bit 5 is SAP level (0 level 1, 1 level 2); bit 6 selects the baseband input (0 selects the intercarrier input); bit 7 is the test enable.
- R7: A control byte whose mode bits are 11 leaves the mode output unchanged but still updates bits 7:2.
- R8: A read returns the byte {stereo flag, SAP flag, 000000}, most significant bit first. The byte is sent again for as long as the master acknowledges. After a master no-acknowledge, data is released.
- R9: The low 4 bits of the second data byte of a write set the monitor select only if the first byte of that write set bit 7. Otherwise the second byte is ignored.
- R10: The monitor select output shows the stored code only while the test enable is set and the code is 13 or less. Codes 14 and 15, or test off, give 0.
- R11: A write that ends with a stop after exactly one data byte clears the monitor select to 0.
- R12: A repeated start in the middle of a byte abandons that byte and restarts address reception.
- R13: A pulse on either line shorter than FILT_LEN system clocks is ignored, so it creates no false start or stop. The default parameters meet a 100 kHz bus clock with wide margin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_n | output | 1 | Low enables the open-drain pull-down on the data line |
| stereo_det_i | input | 1 | Stereo pilot detector flag |
| sap_det_i | input | 1 | SAP carrier detector flag |
| mode_sel | output | 2 | Audio mode: 00 stereo, 01 SAP, 10 both |
| force_mono | output | 1 | Forced mono |
| mute | output | 1 | Output mute |
| alc_en | output | 1 | Automatic level control enable |
| sap_lvl | output | 1 | SAP output level select |
| src_bb | output | 1 | Baseband input select |
| test_en | output | 1 | Test mode enable |
| mon_sel | output | 4 | Monitor point select, 0 = normal |

## Verification
On every cycle the assertions check the following. The pull-down is enabled only during an acknowledge slot or a read bit. The six padding bits of the status byte always drive zero. The mode output never holds 11. The monitor select never exceeds 13. The control register changes only on a completed byte strobe. Behaviour that depends on whole bus sequences needs the bench's directed scenarios: address rejection, partial bytes cut off by a stop or a repeated start, the two-byte test write and its clearing by a one-byte write, multi-byte reads, and glitch rejection. These scenarios also compare the register outputs and the sampled bus against the expected values.

// File: rtl/dec_ctl_pkg.sv
package dec_ctl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_WR, ST_SACK, ST_RD, ST_MACK
   } bus_st_e;

   // control byte, bit 7 first
   typedef struct packed {
      logic       test;
      logic       src_bb;
      logic       sap_lvl;
      logic       alc;
      logic       mute;
      logic       mono;
      logic [1:0] mode;
   } ctl_t;

   localparam logic [1:0] MODE_BAD = 2'b11;
endpackage

// File: rtl/dec_ctl_filt.sv
module dec_ctl_filt #(
   parameter int N_LINES  = 2,
   parameter int FILT_LEN = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] raw,
   output logic [N_LINES-1:0] clean
);
   localparam int CW = (FILT_LEN < 1) ? 1 : $clog2(FILT_LEN + 1);

   if (FILT_LEN < 0 || FILT_LEN > 255) begin : g_bad_len
      $error("dec_ctl_filt: FILT_LEN out of range");
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      logic s1, s2;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
         end else begin
            s1 <= raw[i];
            s2 <= s1;
         end
      end

      if (FILT_LEN == 0) begin : g_bypass
         assign clean[i] = s2;
      end else begin : g_filt
         logic [CW-1:0] run;
         logic          q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run <= '0;
               q   <= 1'b1;
            end else if (s2 == q) begin
               run <= '0;
            end else if (run == CW'(FILT_LEN - 1)) begin
               run <= '0;
               q   <= s2;
            end else begin
               run <= run + 1'b1;
            end
         end
         assign clean[i] = q;
      end
   end
endmodule

// File: rtl/dec_ctl_engine.sv
module dec_ctl_engine
   import dec_ctl_pkg::*;
#(
   parameter logic [6:0] SLV_ADDR = 7'h40
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_f,
   input  logic       sda_f,
   input  logic [7:0] status,
   output logic       drv,
   output logic       byte_stb,
   output logic       byte_first,
   output logic       byte_second,
   output logic [7:0] byte_data,
   output logic       stop_wr1
);
   bus_st_e    st;
   logic       scl_q, sda_q;
   logic [7:0] sh;
   logic [3:0] cnt;
   logic [1:0] nbytes;
   logic       ack_pend, is_rd, mack;

   logic start_c, stop_c, scl_rise, scl_fall;
   logic [7:0] nxt;

   assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;
   assign scl_rise = scl_f & ~scl_q;
   assign scl_fall = ~scl_f & scl_q;
   assign nxt      = {sh[6:0], sda_f};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;  scl_q <= 1'b1;  sda_q <= 1'b1;
         sh <= '0;  cnt <= '0;  nbytes <= '0;
         ack_pend <= 1'b0;  is_rd <= 1'b0;  mack <= 1'b0;  drv <= 1'b0;
         byte_stb <= 1'b0;  byte_first <= 1'b0;  byte_second <= 1'b0;
         byte_data <= '0;  stop_wr1 <= 1'b0;
      end else begin
         scl_q    <= scl_f;
         sda_q    <= sda_f;
         byte_stb <= 1'b0;
         stop_wr1 <= 1'b0;
         if (stop_c) begin
            stop_wr1 <= (st == ST_WR) && (nbytes == 2'd1);
            st       <= ST_IDLE;
            drv      <= 1'b0;
            ack_pend <= 1'b0;
         end else if (start_c) begin
            st       <= ST_ADDR;
            cnt      <= '0;
            nbytes   <= '0;
            drv      <= 1'b0;
            ack_pend <= 1'b0;
         end else if (scl_fall && ack_pend) begin
            ack_pend <= 1'b0;
            st       <= ST_SACK;
            drv      <= 1'b1;
         end else begin
            case (st)
               ST_ADDR: if (scl_rise) begin
                  sh  <= nxt;
                  cnt <= cnt + 1'b1;
                  if (cnt == 4'd7) begin
                     if (nxt[7:1] == SLV_ADDR) begin
                        ack_pend <= 1'b1;
                        is_rd    <= nxt[0];
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_WR: if (scl_rise) begin
                  sh  <= nxt;
                  cnt <= cnt + 1'b1;
                  if (cnt == 4'd7) begin
                     byte_stb    <= 1'b1;
                     byte_data   <= nxt;
                     byte_first  <= (nbytes == 2'd0);
                     byte_second <= (nbytes == 2'd1);
                     nbytes      <= (nbytes == 2'd3) ? nbytes : nbytes + 1'b1;
                     ack_pend    <= 1'b1;
                  end
               end
               ST_SACK: if (scl_fall) begin
                  cnt <= '0;
                  if (is_rd) begin
                     sh  <= status;
                     drv <= ~status[7];
                     st  <= ST_RD;
                  end else begin
                     drv <= 1'b0;
                     st  <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_rise) cnt <= cnt + 1'b1;
                  if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        drv <= 1'b0;
                        st  <= ST_MACK;
                     end else begin
                        sh  <= sh << 1;
                        drv <= ~sh[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) mack <= ~sda_f;
                  if (scl_fall) begin
                     if (mack) begin
                        cnt <= '0;
                        sh  <= status;
                        drv <= ~status[7];
                        st  <= ST_RD;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R3: pull-down only in the acknowledge slot or while sending read data
   a_r3_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
      drv |-> (st == ST_SACK || st == ST_RD));
   // R2: an idle slave never holds the line
   a_r2_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !drv);
   // R8: status padding bits always go out as zero
   a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RD && cnt >= 4'd3) |-> drv);
endmodule

// File: rtl/dec_ctl_regs.sv
module dec_ctl_regs
   import dec_ctl_pkg::*;
#(
   parameter int MON_W    = 4,
   parameter int MON_LAST = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_stb,
   input  logic             byte_first,
   input  logic             byte_second,
   input  logic [7:0]       byte_data,
   input  logic             stop_wr1,
   output ctl_t             ctl_o,
   output logic [MON_W-1:0] mon_o
);
   if (MON_W < 1 || MON_W > 8 || MON_LAST >= (1 << MON_W)) begin : g_bad_mon
      $error("dec_ctl_regs: monitor select parameters inconsistent");
   end

   ctl_t             ctl_q;
   logic [MON_W-1:0] mon_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         mon_q <= '0;
      end else begin
         if (byte_stb && byte_first)
            ctl_q <= ctl_t'({byte_data[7:2],
                     (byte_data[1:0] == MODE_BAD) ? ctl_q.mode : byte_data[1:0]});
         if (byte_stb && byte_second && ctl_q.test)
            mon_q <= byte_data[MON_W-1:0];
         if (stop_wr1)
            mon_q <= '0;
      end
   end

   assign ctl_o = ctl_q;
   assign mon_o = (ctl_q.test && mon_q <= MON_W'(MON_LAST)) ? mon_q : '0;

   // R4: register moves only on a completed byte
   a_r4_hold_without_byte: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_stb |=> $stable(ctl_q));
   // R7: the prohibited mode never reaches the output
   a_r7_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.mode != MODE_BAD);
endmodule

// File: rtl/dec_ctl_i2c.sv
module dec_ctl_i2c
   import dec_ctl_pkg::*;
#(
   parameter logic [6:0] SLV_ADDR = 7'h40,
   parameter int         FILT_LEN = 8,
   parameter int         MON_W    = 4,
   parameter int         MON_LAST = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe_n,
   input  logic             stereo_det_i,
   input  logic             sap_det_i,
   output logic [1:0]       mode_sel,
   output logic             force_mono,
   output logic             mute,
   output logic             alc_en,
   output logic             sap_lvl,
   output logic             src_bb,
   output logic             test_en,
   output logic [MON_W-1:0] mon_sel
);
   logic [1:0] clean;
   logic       drv, byte_stb, byte_first, byte_second, stop_wr1;
   logic [7:0] byte_data;
   ctl_t       ctl;

   dec_ctl_filt #(.N_LINES(2), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw({scl_i, sda_i}), .clean(clean));

   dec_ctl_engine #(.SLV_ADDR(SLV_ADDR)) u_eng (
      .clk(clk), .rst_n(rst_n), .scl_f(clean[1]), .sda_f(clean[0]),
      .status({stereo_det_i, sap_det_i, 6'b0}), .drv(drv),
      .byte_stb(byte_stb), .byte_first(byte_first), .byte_second(byte_second),
      .byte_data(byte_data), .stop_wr1(stop_wr1));

   dec_ctl_regs #(.MON_W(MON_W), .MON_LAST(MON_LAST)) u_regs (
      .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_first(byte_first),
      .byte_second(byte_second), .byte_data(byte_data), .stop_wr1(stop_wr1),
      .ctl_o(ctl), .mon_o(mon_sel));

   assign sda_oe_n   = ~drv;
   assign mode_sel   = ctl.mode;
   assign force_mono = ctl.mono;
   assign mute       = ctl.mute;
   assign alc_en     = ctl.alc;
   assign sap_lvl    = ctl.sap_lvl;
   assign src_bb     = ctl.src_bb;
   assign test_en    = ctl.test;

   // R10: monitor output stays inside the legal code range
   a_r10_mon_range: assert property (@(posedge clk) disable iff (!rst_n)
      mon_sel <= MON_W'(MON_LAST));
   // R11: one-byte write leaves the monitor at normal
   a_r11_clear_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop_wr1 |=> (mon_sel == '0));
endmodule

// File: tb/dec_ctl_i2c_tb.sv
`timescale 1ns/1ps
module dec_ctl_i2c_tb;
   localparam int Q = 25;   // clocks per quarter bus bit

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl = 1'b1, sda_m = 1'b1;
   logic st_det = 1'b0, sap_det = 1'b0;
   logic sda_oe_n, force_mono, mute, alc_en, sap_lvl, src_bb, test_en;
   logic [1:0] mode_sel;
   logic [3:0] mon_sel;
   logic sda_line;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;
   assign sda_line = sda_m & sda_oe_n;

   dec_ctl_i2c u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_n(sda_oe_n),
      .stereo_det_i(st_det), .sap_det_i(sap_det), .mode_sel(mode_sel),
      .force_mono(force_mono), .mute(mute), .alc_en(alc_en), .sap_lvl(sap_lvl),
      .src_bb(src_bb), .test_en(test_en), .mon_sel(mon_sel));

   function automatic logic [7:0] obs();
      return {test_en, src_bb, sap_lvl, alc_en, mute, force_mono, mode_sel};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wq(); repeat (Q) @(posedge clk); #1; endtask

   task automatic bus_start(); sda_m = 1; scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq(); endtask
   task automatic bus_rstart(); sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq(); endtask
   task automatic bus_stop(); sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(); endtask

   task automatic send_bit(input logic b, input logic gl);
      sda_m = b; wq(); scl = 1; wq();
      if (gl) begin sda_m = 1; repeat (3) @(posedge clk); #1; sda_m = b; end
      wq(); scl = 0; wq();
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1; wq(); scl = 1; wq(); b = sda_line; wq(); scl = 0; wq();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack, input int gl_at);
      for (int i = 7; i >= 0; i--) send_bit(d[i], i == gl_at);
      get_bit(ack);
   endtask

   task automatic wr_txn(input logic [7:0] d0, input logic [7:0] d1, input int n,
                         input string tag);
      logic ack;
      bus_start();
      send_byte(8'h80, ack, -1);
      chk({tag, " R1 addr ack"}, {7'b0, ack}, 8'h00);
      send_byte(d0, ack, -1);
      chk({tag, " R3 data ack"}, {7'b0, ack}, 8'h00);
      if (n > 1) begin
         send_byte(d1, ack, -1);
         chk({tag, " R3 data ack"}, {7'b0, ack}, 8'h00);
      end
      bus_stop();
   endtask

   task automatic t_reset();
      chk("R5 ctl reset", obs(), 8'h00);
      chk("R5 mon reset", {4'b0, mon_sel}, 8'h00);
      chk("R5 sda released", {7'b0, sda_oe_n}, 8'h01);
   endtask

   task automatic t_write_fields();
      wr_txn(8'h7D, 8'h00, 1, "wr7D");
      chk("R6 fields 7D", obs(), 8'h7D);
      wr_txn(8'h02, 8'h00, 1, "wr02");
      chk("R6 mode both", obs(), 8'h02);
   endtask

   task automatic t_mode_bad();
      wr_txn(8'h13, 8'h00, 1, "wr13");
      chk("R7 mode 11 kept old mode", obs(), 8'h12);
   endtask

   task automatic t_partial();
      logic ack;
      bus_start();
      send_byte(8'h80, ack, -1);
      for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
      bus_stop();
      chk("R4 partial byte dropped", obs(), 8'h12);
   endtask

   task automatic t_mismatch();
      logic ack;
      bus_start();
      send_byte(8'h82, ack, -1);
      chk("R2 no ack on wrong addr", {7'b0, ack}, 8'h01);
      send_byte(8'h00, ack, -1);
      chk("R2 no ack on ignored data", {7'b0, ack}, 8'h01);
      bus_stop();
      chk("R2 register untouched", obs(), 8'h12);
   endtask

   task automatic t_rstart();
      logic ack;
      bus_start();
      for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
      bus_rstart();
      send_byte(8'h80, ack, -1);
      chk("R12 addr ack after repeated start", {7'b0, ack}, 8'h00);
      send_byte(8'h21, ack, -1);
      bus_stop();
      chk("R12 write after repeated start", obs(), 8'h21);
   endtask

   task automatic rd_txn(input int n, input logic [7:0] exp, input string tag);
      logic ack, b;
      logic [7:0] d;
      bus_start();
      send_byte(8'h81, ack, -1);
      chk({tag, " R1 read addr ack"}, {7'b0, ack}, 8'h00);
      for (int k = 0; k < n; k++) begin
         for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
         chk({tag, " R8 status byte"}, d, exp);
         send_bit(k == n - 1, 1'b0);
      end
      chk({tag, " R8 released after nack"}, {7'b0, sda_oe_n}, 8'h01);
      bus_stop();
   endtask

   task automatic t_read();
      st_det = 1; sap_det = 0;
      rd_txn(1, 8'h80, "rd1");
      st_det = 0; sap_det = 1;
      rd_txn(2, 8'h40, "rd2");
      st_det = 1; sap_det = 1;
      rd_txn(1, 8'hC0, "rd3");
      chk("R8 read leaves control", obs(), 8'h21);
   endtask

   task automatic t_test_mode();
      wr_txn(8'h80, 8'h05, 2, "tm5");
      chk("R9 test enable", obs(), 8'h80);
      chk("R9 monitor code 5", {4'b0, mon_sel}, 8'h05);
      wr_txn(8'h80, 8'h0E, 2, "tm14");
      chk("R10 code 14 no operation", {4'b0, mon_sel}, 8'h00);
      wr_txn(8'h80, 8'h0D, 2, "tm13");
      chk("R9 monitor code 13", {4'b0, mon_sel}, 8'h0D);
      wr_txn(8'h80, 8'h00, 1, "tm1b");
      chk("R11 one-byte write clears monitor", {4'b0, mon_sel}, 8'h00);
      wr_txn(8'h80, 8'h03, 2, "tm3");
      chk("R9 monitor code 3", {4'b0, mon_sel}, 8'h03);
      wr_txn(8'h00, 8'h07, 2, "tmoff");
      chk("R10 test off gives normal", {4'b0, mon_sel}, 8'h00);
      chk("R9 test off control", obs(), 8'h00);
   endtask

   task automatic t_glitch();
      logic ack;
      bus_start();
      send_byte(8'h80, ack, -1);
      send_byte(8'h44, ack, 7);
      chk("R13 ack despite glitch", {7'b0, ack}, 8'h00);
      bus_stop();
      chk("R13 glitch filtered", obs(), 8'h44);
   endtask

   initial begin
      repeat (10) @(posedge clk);
      #1 rst_n = 1;
      wq();
      t_reset();
      t_write_fields();
      t_mode_bad();
      t_partial();
      t_mismatch();
      t_rstart();
      t_read();
      t_test_mode();
      t_glitch();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule